// File: doc/BRIEF.md
# VLAN Table Command Engine

This block holds a small VLAN table in on-chip flops and exposes it through a register-mapped command interface. Software places a VLAN ID in the VID register and per-port member/state codes in three packed data registers. It then writes the operation register with the busy bit set and an opcode. The engine scans the table one entry per clock. When the command is done it clears busy, and software polls for that.

Four commands exist: flush every entry, load or purge one entry, fetch the next valid VID above the one in the VID register, and fetch-and-clear the latched violation. On the data side, a lookup port checks each ingress VID and ingress port against the table. The first miss or membership violation is held for software to collect, and a pending output stays high until then. There is no separate database-number register: the 8-bit database number travels in the operation register.

Top module: `vlan_cmd_table`

## Requirements
- R1: After reset the operation, VID and data registers read zero, busy (op bit 15) is clear, the table is empty and `viol_pending` is low.
- R2: Writing the operation register (address 0) with bit 15 set starts the opcode in bits 14:12 (1 = flush, 3 = load/purge, 4 = get-next, 7 = get-and-clear violation). Bit 15 reads 1 until the command completes and then reads 0.
- R3: Flush, load/purge and get-next keep busy set for at least DEPTH cycles, because each scans the table one entry per cycle.
- R4: The VID register (address 1) holds VID bits 11:0 in bits 11:0, the valid flag in bit 12 and VID bit 12 in bit 13.
- R5: Load/purge with the valid flag set stores the VID, the three data words (addresses 2 to 4) and the database number. Database bits 3:0 are taken from op bits 3:0 and bits 7:4 from op bits 11:8. Loading a VID that is already present overwrites it.
- R6: Load/purge with the valid flag clear removes the entry for that VID.
- R7: Get-next returns the lowest stored VID strictly above the VID in the VID register. It writes back that VID with valid set, the entry's data words, and its database number in op bits 3:0 and 11:8, so repeating it walks the table in ascending order.
- R8: A VID field of all ones (0x1FFF) starts get-next from the bottom of the table. When no stored VID lies above the start point, the VID register becomes 0x2FFF (valid clear, VID all ones).
- R9: Flush invalidates every entry.
- R10: Port p's member code lies at bits 4p+1:4p and its state at bits 4p+3:4p+2 of {data2, data1, data0}. The member code 2'b11 means "not a member".
- R11: A lookup whose VID has no entry latches a miss violation. A lookup that hits an entry whose member code for the ingress port is 2'b11 latches a member violation. Only the first violation is held, and `viol_pending` is high while one is held.
- R12: Get-and-clear violation writes the source port to op bits 3:0, the miss flag to op bit 5 and the member flag to op bit 6. It loads the offending VID into the VID register with valid set, then clears the held violation.
- R13: A write to the operation register while busy is set is ignored, and the running command completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_waddr | input | 3 | Write address (0 op, 1 VID, 2 to 4 data) |
| cfg_wdata | input | 16 | Write data |
| cfg_raddr | input | 3 | Read address |
| cfg_rdata | output | 16 | Read data (combinational) |
| lkp_valid | input | 1 | Lookup request this cycle |
| lkp_vid | input | 13 | Lookup VID |
| lkp_port | input | 4 | Ingress port of the lookup |
| viol_pending | output | 1 | A violation is held |

## Verification
The assertions assume that software obeys the polling contract: it does not rewrite the VID or data registers while a command runs, and `lkp_port` stays below the port count. The stimulus always waits for busy to clear before it touches those registers. It breaks the contract only on purpose, with a second opcode write during a running get-next. It also keeps lookups out of the cycle in which a get-and-clear completes, so the order in which a new violation and the clear land never decides a result.

// File: rtl/vlan_cmd_table.sv
module vlan_cmd_table #(
  parameter int DEPTH  = 64,
  parameter int NPORTS = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [2:0]  cfg_waddr,
  input  logic [15:0] cfg_wdata,
  input  logic [2:0]  cfg_raddr,
  output logic [15:0] cfg_rdata,
  input  logic        lkp_valid,
  input  logic [12:0] lkp_vid,
  input  logic [3:0]  lkp_port,
  output logic        viol_pending
);
  localparam int NDATA = (NPORTS + 3) / 4;
  localparam int DW    = NDATA * 16;
  localparam int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);
  localparam logic [2:0] OPC_FLUSH = 3'd1, OPC_LOAD = 3'd3, OPC_NEXT = 3'd4, OPC_VIOL = 3'd7;

  typedef enum logic [1:0] {S_IDLE, S_SCAN, S_FIN} st_t;
  st_t st;

  logic [15:0]   op_q;
  logic [13:0]   vid_q;
  logic [DW-1:0] dat_q;
  logic          tv   [DEPTH];
  logic [12:0]   tvid [DEPTH];
  logic [7:0]    tfid [DEPTH];
  logic [DW-1:0] tdat [DEPTH];
  logic [IW-1:0] idx, mi, fi, bi;
  logic          mf, ff, bf;
  logic [12:0]   bv;
  logic          pend_q, vmem_q, vmiss_q;
  logic [3:0]    vspid_q;
  logic [12:0]   vvid_q;

  wire [2:0]  opc  = op_q[14:12];
  wire        busy = op_q[15];
  wire [12:0] tgt  = {vid_q[13], vid_q[11:0]};
  wire        wrap = (tgt == 13'h1FFF);
  wire        clr  = (st == S_FIN) && (opc == OPC_VIOL);
  wire [7:0]  dbn  = {op_q[11:8], op_q[3:0]};

  always_comb begin
    cfg_rdata = 16'h0;
    case (cfg_raddr)
      3'd0: cfg_rdata = op_q;
      3'd1: cfg_rdata = {2'b00, vid_q};
      default: begin
        for (int k = 0; k < NDATA; k++)
          if (int'(cfg_raddr) == k + 2) cfg_rdata = dat_q[k*16 +: 16];
      end
    endcase
  end

  logic       hit;
  logic [1:0] hmem;
  always_comb begin
    hit  = 1'b0;
    hmem = 2'b00;
    for (int i = 0; i < DEPTH; i++)
      if (!hit && tv[i] && tvid[i] == lkp_vid) begin
        hit  = 1'b1;
        hmem = tdat[i][{lkp_port, 2'b00} +: 2];
      end
  end
  wire v_miss = lkp_valid && !hit;
  wire v_mem  = lkp_valid && hit && (hmem == 2'b11);
  assign viol_pending = pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0; vmem_q <= 1'b0; vmiss_q <= 1'b0;
      vspid_q <= '0; vvid_q <= '0;
    end else if (clr) begin
      pend_q <= 1'b0; vmem_q <= 1'b0; vmiss_q <= 1'b0;
      vspid_q <= '0; vvid_q <= '0;
    end else if (!pend_q && (v_miss || v_mem)) begin
      pend_q <= 1'b1; vmem_q <= v_mem; vmiss_q <= v_miss;
      vspid_q <= lkp_port; vvid_q <= lkp_vid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; op_q <= '0; vid_q <= '0; dat_q <= '0;
      idx <= '0; mi <= '0; fi <= '0; bi <= '0;
      mf <= 1'b0; ff <= 1'b0; bf <= 1'b0; bv <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        tv[i] <= 1'b0; tvid[i] <= '0; tfid[i] <= '0; tdat[i] <= '0;
      end
    end else begin
      if (cfg_we) begin
        if (cfg_waddr == 3'd0 && !busy) begin
          op_q <= cfg_wdata;
          if (cfg_wdata[15]) begin
            idx <= '0; mf <= 1'b0; ff <= 1'b0; bf <= 1'b0;
            st  <= (cfg_wdata[14:12] == OPC_FLUSH || cfg_wdata[14:12] == OPC_LOAD ||
                    cfg_wdata[14:12] == OPC_NEXT) ? S_SCAN : S_FIN;
          end
        end
        if (cfg_waddr == 3'd1) vid_q <= cfg_wdata[13:0];
        for (int k = 0; k < NDATA; k++)
          if (int'(cfg_waddr) == k + 2) dat_q[k*16 +: 16] <= cfg_wdata;
      end
      if (st == S_SCAN) begin
        case (opc)
          OPC_FLUSH: tv[idx] <= 1'b0;
          OPC_LOAD: begin
            if (tv[idx] && tvid[idx] == tgt) begin mf <= 1'b1; mi <= idx; end
            if (!tv[idx] && !ff) begin ff <= 1'b1; fi <= idx; end
          end
          default: begin
            if (tv[idx] && (wrap || tvid[idx] > tgt) && (!bf || tvid[idx] < bv)) begin
              bf <= 1'b1; bi <= idx; bv <= tvid[idx];
            end
          end
        endcase
        idx <= idx + 1'b1;
        if (idx == LAST) st <= S_FIN;
      end
      if (st == S_FIN) begin
        st <= S_IDLE;
        op_q[15] <= 1'b0;
        case (opc)
          OPC_LOAD: begin
            if (vid_q[12]) begin
              if (mf || ff) begin
                tv[mf ? mi : fi]   <= 1'b1;
                tvid[mf ? mi : fi] <= tgt;
                tfid[mf ? mi : fi] <= dbn;
                tdat[mf ? mi : fi] <= dat_q;
              end
            end else if (mf) tv[mi] <= 1'b0;
          end
          OPC_NEXT: begin
            if (bf) begin
              vid_q <= {bv[12], 1'b1, bv[11:0]};
              dat_q <= tdat[bi];
              op_q  <= {1'b0, opc, tfid[bi][7:4], op_q[7:4], tfid[bi][3:0]};
            end else vid_q <= 14'h2FFF;
          end
          OPC_VIOL: begin
            op_q  <= {1'b0, opc, 4'h0, 1'b0, vmem_q, vmiss_q, 1'b0, vspid_q};
            vid_q <= {vvid_q[12], pend_q, vvid_q[11:0]};
          end
          default: ;
        endcase
      end
    end
  end

  AST_ACTIVE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE) |-> op_q[15]); // R2
  AST_OPC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q[15] && cfg_we && cfg_waddr == 3'd0) |=> $stable(op_q[14:12])); // R13
  AST_FIRST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !clr) |=> (pend_q && $stable(vvid_q) && $stable(vspid_q))); // R11
  AST_VIOL_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !viol_pending); // R12
  AST_NEXT_EXHAUST: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FIN && opc == OPC_NEXT && !bf) |=> (vid_q == 14'h2FFF)); // R8
endmodule

// File: tb/tb_vlan_cmd_table.sv
module tb_vlan_cmd_table;
  localparam int DEPTH = 64;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_waddr = '0, cfg_raddr = '0;
  logic [15:0] cfg_wdata = '0, cfg_rdata;
  logic lkp_valid = 1'b0;
  logic [12:0] lkp_vid = '0;
  logic [3:0] lkp_port = '0;
  logic viol_pending;
  int tests = 0, fails = 0;

  vlan_cmd_table #(.DEPTH(DEPTH), .NPORTS(12)) dut (.*);

  always #10 clk = ~clk;

  // {vid[12:0], db[7:0], data0, data1, data2}, ascending VID order
  localparam logic [68:0] VEC [5] = '{
    {13'h0003, 8'h12, 16'hA5C3, 16'h0030, 16'h0F0F},
    {13'h0010, 8'hA7, 16'h1111, 16'h2222, 16'h3333},
    {13'h00FF, 8'h5E, 16'h4444, 16'h5555, 16'h6666},
    {13'h0FFE, 8'h81, 16'h7777, 16'h8888, 16'h9999},
    {13'h1005, 8'h3C, 16'hABCD, 16'hEF01, 16'h2345}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_waddr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [15:0] d);
    cfg_raddr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic wait_idle(output int n);
    logic [15:0] v;
    n = 0;
    rd(3'd0, v);
    while (v[15] && n < 1000) begin
      @(negedge clk);
      n++;
      rd(3'd0, v);
    end
  endtask

  function automatic logic [15:0] venc(logic [12:0] v, logic ok);
    return {2'b00, v[12], ok, v[11:0]};
  endfunction

  function automatic logic [15:0] opw(logic [2:0] opc, logic [7:0] db);
    return {1'b1, opc, db[7:4], 4'h0, db[3:0]};
  endfunction

  task automatic lookup(logic [12:0] v, logic [3:0] p);
    @(negedge clk);
    lkp_valid = 1'b1; lkp_vid = v; lkp_port = p;
    @(negedge clk);
    lkp_valid = 1'b0;
  endtask

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] r;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(3'd0, r); check("R1 op reset", r, 16'h0);
    rd(3'd1, r); check("R1 vid reset", r, 16'h0);
    rd(3'd3, r); check("R1 data reset", r, 16'h0);
    check("R1 pending reset", viol_pending, 0);

    // vector table: load in reverse order (R5)
    for (int i = 4; i >= 0; i--) begin
      wr(3'd1, venc(VEC[i][68:56], 1'b1));
      wr(3'd2, VEC[i][47:32]);
      wr(3'd3, VEC[i][31:16]);
      wr(3'd4, VEC[i][15:0]);
      wr(3'd0, opw(3'd3, VEC[i][55:48]));
      rd(3'd0, r); check("R2 busy set", r[15], 1);
      wait_idle(n);
      check("R3 load busy length", 32'(n >= DEPTH), 1);
      rd(3'd0, r); check("R2 busy cleared", r[15], 0);
    end

    // walk (R7, R8 wrap start)
    wr(3'd1, 16'h2FFF);
    for (int i = 0; i < 5; i++) begin
      wr(3'd0, 16'hC000);
      wait_idle(n);
      check("R3 next busy length", 32'(n >= DEPTH), 1);
      rd(3'd1, r); check("R7 R4 walk vid", r, venc(VEC[i][68:56], 1'b1));
      rd(3'd2, r); check("R7 walk data0", r, VEC[i][47:32]);
      rd(3'd3, r); check("R7 walk data1", r, VEC[i][31:16]);
      rd(3'd4, r); check("R7 walk data2", r, VEC[i][15:0]);
      rd(3'd0, r); check("R5 R7 walk db", {r[11:8], r[3:0]}, VEC[i][55:48]);
    end
    wr(3'd0, 16'hC000); wait_idle(n);
    rd(3'd1, r); check("R8 exhausted", r, 16'h2FFF);

    // overwrite existing VID (R5)
    wr(3'd1, venc(VEC[1][68:56], 1'b1));
    wr(3'd2, 16'hBEEF);
    wr(3'd0, opw(3'd3, 8'h44)); wait_idle(n);
    wr(3'd1, venc(VEC[0][68:56], 1'b0));
    wr(3'd0, 16'hC000); wait_idle(n);
    rd(3'd2, r); check("R5 overwrite data", r, 16'hBEEF);
    rd(3'd0, r); check("R5 overwrite db", {r[11:8], r[3:0]}, 8'h44);

    // purge VEC[2] (R6)
    wr(3'd1, venc(VEC[2][68:56], 1'b0));
    wr(3'd0, opw(3'd3, 8'h00)); wait_idle(n);
    wr(3'd1, venc(VEC[1][68:56], 1'b0));
    wr(3'd0, 16'hC000); wait_idle(n);
    rd(3'd1, r); check("R6 purged skipped", r, venc(VEC[3][68:56], 1'b1));

    // opcode write while busy (R13)
    wr(3'd1, 16'h2FFF);
    wr(3'd0, 16'hC000);
    wr(3'd0, 16'h9000);
    wait_idle(n);
    rd(3'd1, r); check("R13 running cmd result", r, venc(VEC[0][68:56], 1'b1));
    rd(3'd0, r); check("R13 opcode kept", r[14:12], 3'd4);
    wr(3'd0, 16'hC000); wait_idle(n);
    rd(3'd1, r); check("R13 table intact", r, venc(VEC[1][68:56], 1'b1));

    // violations (R11, R12, R10)
    lookup(13'h0007, 4'd3);
    check("R11 miss pending", viol_pending, 1);
    lookup(VEC[0][68:56], 4'd5);
    wr(3'd0, 16'hF000); wait_idle(n);
    rd(3'd0, r); check("R12 R11 first viol kept", r, 16'h7023);
    rd(3'd1, r); check("R12 viol vid", r, 16'h1007);
    check("R12 cleared", viol_pending, 0);
    lookup(VEC[0][68:56], 4'd4);
    check("R10 member code 00 ok", viol_pending, 0);
    lookup(VEC[0][68:56], 4'd5);
    check("R10 R11 member viol", viol_pending, 1);
    wr(3'd0, 16'hF000); wait_idle(n);
    rd(3'd0, r); check("R12 member flags", r, 16'h7045);
    rd(3'd1, r); check("R12 member vid", r, venc(VEC[0][68:56], 1'b1));

    // flush (R9)
    wr(3'd0, 16'h9000); wait_idle(n);
    check("R3 flush busy length", 32'(n >= DEPTH), 1);
    wr(3'd1, 16'h2FFF);
    wr(3'd0, 16'hC000); wait_idle(n);
    rd(3'd1, r); check("R9 table empty", r, 16'h2FFF);
    lookup(VEC[1][68:56], 4'd0);
    check("R9 R11 miss after flush", viol_pending, 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule